// File: doc/BRIEF.md
# UART Receive Queue with Level Trigger and Stale-Data Timeout

This block buffers received characters for one UART channel between the serial receiver and the register decoder. Bytes arrive with a one-cycle valid strobe and leave with a one-cycle pop strobe. In queue mode the block holds up to 16 bytes. With the queue switched off it holds a single byte, like a plain holding register.

Two interrupt flags tell the host when to read. The level flag is raised once the number of stored bytes reaches a threshold chosen by a two-bit select. This lets software read in bursts. A fill level below the threshold would never raise that flag, so a second flag reports bytes left unread for four character times. Data still reaches the host when traffic stops short of the threshold.

Every output is registered. A strobe sampled at a rising edge shows its effect on the outputs just after that same edge.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `empty` is 1, `level` is 0 and `trig_irq`, `tout_irq` and `overrun` are all 0.
- R2: With `fifo_en`=1 the block stores up to 16 bytes in arrival order. `head_data` shows the oldest byte, an accepted pop removes it, and `level` gives the stored count.
- R3: With `fifo_en`=0 the capacity is one byte.
- R4: A push while the store is at capacity, with no pop in the same cycle, is dropped. It sets `overrun`, which stays at 1 until the next mode change. The stored bytes do not change.
- R5: A pop while the store is empty has no effect on `level`, `empty` or `head_data`.
- R6: In queue mode, `trig_sel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 bytes. In single-byte mode the threshold is 1. `trig_irq` becomes 1 at the edge where `level` becomes equal to the threshold.
- R7: `trig_irq` returns to 0 at the edge where `level` drops below the threshold.
- R8: In queue mode, while the store is not empty, `tout_irq` becomes 1 at the fourth `char_tick` pulse that has no accepted push or pop since the last such event. An accepted push or pop restarts the count.
- R9: `tout_irq` returns to 0 on an accepted pop. It is never raised in single-byte mode.
- R10: When `fifo_en` differs from its value at the previous edge, the store is flushed: `level` becomes 0, `overrun` and `tout_irq` are cleared, and a push or pop in that cycle is ignored.
- R11: A push and a pop in the same cycle at full capacity are both accepted. `level` stays unchanged and the pushed byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 16-byte queue mode, 0: single-byte mode |
| trig_sel | input | 2 | Threshold select for the level interrupt |
| push | input | 1 | Received byte valid strobe |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Host read strobe |
| char_tick | input | 1 | One-cycle pulse per character time |
| head_data | output | 8 | Oldest stored byte |
| level | output | 5 | Number of stored bytes |
| empty | output | 1 | 1 when no byte is stored |
| trig_irq | output | 1 | Level-threshold interrupt flag |
| tout_irq | output | 1 | Stale-data timeout flag |
| overrun | output | 1 | Sticky flag for a dropped byte |

## Verification
The bench uses the default parameters: 16 entries of 8 bits and a timeout of four character times. At these sizes it can fill the store one byte at a time through every level from 1 to 16 for each of the four threshold codes. It then drains it fully and compares every head byte against an arithmetic pattern. The small timeout window lets the bench place ticks just short of expiry and exactly at expiry, with a push or pop in between. Single-byte mode, overflow, flushes on mode change and a simultaneous push and pop at full capacity are also driven.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_QUARTER  = 2'd1,
        TRIG_HALF     = 2'd2,
        TRIG_NEARFULL = 2'd3
    } trig_code_e;

    // Threshold in bytes for each select code in queue mode
    function automatic int unsigned trig_bytes(input trig_code_e code);
        case (code)
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return 4;
            TRIG_HALF:    return 8;
            default:      return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level_q_o,
    output logic [LW-1:0]    level_nxt
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [LW-1:0] lvl;
    } ring_t;

    ring_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) begin
            return '0;
        end
        return p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) begin
                st_d.wr = bump(st_q.wr);
            end
            if (pop_ok) begin
                st_d.rd = bump(st_q.rd);
            end
            st_d.lvl = st_q.lvl + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Data array: written only, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem_q[st_q.wr] <= wdata;
        end
    end

    assign head      = mem_q[st_q.rd];
    assign level_q_o = st_q.lvl;
    assign level_nxt = st_d.lvl;

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [LW-1:0] level_nxt,
    output logic          irq
);

    typedef struct packed {
        logic flag;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic [LW-1:0] thr;

    always_comb begin
        int unsigned raw;
        raw = fifo_en ? trig_bytes(trig_code_e'(trig_sel)) : 1;
        if (raw > DEPTH) begin
            raw = DEPTH;
        end
        thr = LW'(raw);
    end

    always_comb begin
        st_d = st_q;
        if (level_nxt == thr) begin
            st_d.flag = 1'b1;
        end else if (level_nxt < thr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.flag;

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int unsigned TO_CHARS = 4,
    localparam int unsigned CW = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush,
    input  logic activity,
    input  logic pop_ok,
    input  logic nonempty,
    input  logic tick,
    output logic irq
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } tmr_t;

    tmr_t st_d, st_q;
    logic counting;

    assign counting = enable && nonempty && tick;

    always_comb begin
        st_d = st_q;
        if (flush || activity) begin
            st_d.cnt = '0;
        end else if (counting && (st_q.cnt < CW'(TO_CHARS - 1))) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end

        if (flush || pop_ok) begin
            st_d.flag = 1'b0;
        end else if (!activity && counting && (st_q.cnt == CW'(TO_CHARS - 1))) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.flag;

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned TO_CHARS = 4,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             char_tick,
    output logic [WIDTH-1:0] head_data,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             trig_irq,
    output logic             tout_irq,
    output logic             overrun
);

    typedef struct packed {
        logic en_prev;
        logic ovr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          flush;
    logic          push_ok;
    logic          pop_ok;
    logic          at_cap;
    logic [LW-1:0] cap;
    logic [LW-1:0] lvl_q;
    logic [LW-1:0] lvl_nxt;

    assign flush   = (fifo_en != st_q.en_prev);
    assign cap     = fifo_en ? LW'(DEPTH) : LW'(1);
    assign at_cap  = (lvl_q >= cap);
    assign pop_ok  = pop && (lvl_q != '0) && !flush;
    assign push_ok = push && !flush && (!at_cap || pop_ok);

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = fifo_en;
        if (flush) begin
            st_d.ovr = 1'b0;
        end else if (push && !push_ok) begin
            st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rxq_ring #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH)
    ) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wdata    (push_data),
        .head     (head_data),
        .level_q_o(lvl_q),
        .level_nxt(lvl_nxt)
    );

    rxq_trig #(
        .DEPTH(DEPTH)
    ) trig_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .level_nxt(lvl_nxt),
        .irq      (trig_irq)
    );

    rxq_timer #(
        .TO_CHARS(TO_CHARS)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (fifo_en),
        .flush   (flush),
        .activity(push_ok || pop_ok),
        .pop_ok  (pop_ok),
        .nonempty(lvl_q != '0),
        .tick    (char_tick),
        .irq     (tout_irq)
    );

    assign level   = lvl_q;
    assign empty   = (lvl_q == '0);
    assign overrun = st_q.ovr;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          push,
    input logic          pop,
    input logic          flush,
    input logic [LW-1:0] level,
    input logic          empty,
    input logic          trig_irq,
    input logic          tout_irq,
    input logic          overrun
);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0) && !overrun && !tout_irq);

    // R5
    hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !flush && push && !pop && level == LW'(DEPTH)) |=> overrun);

    // R7
    trig_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> !empty);

    // R8
    tout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout_irq |-> !empty);

    // R9
    tout_pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_irq && pop) |=> !tout_irq);

endmodule

bind uart_rx_buffer rxq_checker #(
    .DEPTH(DEPTH)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .push    (push),
    .pop     (pop),
    .flush   (flush),
    .level   (level),
    .empty   (empty),
    .trig_irq(trig_irq),
    .tout_irq(tout_irq),
    .overrun (overrun)
);

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic       push = 1'b0;
    logic [7:0] push_data = 8'd0;
    logic       pop = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] head_data;
    logic [4:0] level;
    logic       empty;
    logic       trig_irq;
    logic       tout_irq;
    logic       overrun;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uart_rx_buffer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .push     (push),
        .push_data(push_data),
        .pop      (pop),
        .char_tick(char_tick),
        .head_data(head_data),
        .level    (level),
        .empty    (empty),
        .trig_irq (trig_irq),
        .tout_irq (tout_irq),
        .overrun  (overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic [7:0] d, input logic pp, input logic t);
        push      = p;
        push_data = d;
        pop       = pp;
        char_tick = t;
        @(posedge clk);
        #1;
        push      = 1'b0;
        pop       = 1'b0;
        char_tick = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        fifo_en = m;
        step(1'b0, 8'd0, 1'b0, 1'b0);
    endtask

    function automatic int thr_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 empty", int'(empty), 1);
        chk("R1 level", int'(level), 0);
        chk("R1 trig", int'(trig_irq), 0);
        chk("R1 tout", int'(tout_irq), 0);
        chk("R1 overrun", int'(overrun), 0);
        rst_n = 1'b1;
        repeat (2) step(1'b0, 8'd0, 1'b0, 1'b0);

        // R2 R4 R6 R7: fill and drain for every threshold code
        for (int code = 0; code < 4; code++) begin
            int thr;
            thr = thr_of(code);
            trig_sel = 2'(code);
            set_mode(1'b0);
            set_mode(1'b1);
            chk("R10 flush overrun", int'(overrun), 0);
            for (int i = 1; i <= 16; i++) begin
                step(1'b1, 8'(code * 16 + i), 1'b0, 1'b0);
                chk("R2 fill level", int'(level), i);
                chk("R6 trig on fill", int'(trig_irq), int'(i >= thr));
            end
            step(1'b1, 8'hEE, 1'b0, 1'b0);
            chk("R4 overrun set", int'(overrun), 1);
            chk("R4 level kept", int'(level), 16);
            chk("R4 head kept", int'(head_data), code * 16 + 1);
            for (int i = 1; i <= 16; i++) begin
                chk("R2 head order", int'(head_data), code * 16 + i);
                step(1'b0, 8'd0, 1'b1, 1'b0);
                chk("R2 drain level", int'(level), 16 - i);
                chk("R7 trig on drain", int'(trig_irq), int'((16 - i) >= thr));
            end
            chk("R4 overrun sticky", int'(overrun), 1);
            // R5 pop on empty
            step(1'b0, 8'd0, 1'b1, 1'b0);
            chk("R5 level", int'(level), 0);
            chk("R5 empty", int'(empty), 1);
        end

        // R8 R9 timeout
        trig_sel = 2'd3;
        set_mode(1'b0);
        set_mode(1'b1);
        step(1'b1, 8'h11, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R8 before expiry", int'(tout_irq), 0);
        step(1'b1, 8'h22, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R8 restart on push", int'(tout_irq), 0);
        step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R8 expiry", int'(tout_irq), 1);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R9 pop clears", int'(tout_irq), 0);
        chk("R9 head next", int'(head_data), 8'h22);
        for (int k = 0; k < 3; k++) step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R8 restart on pop", int'(tout_irq), 0);
        step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R8 second expiry", int'(tout_irq), 1);
        // R10 mode change clears tout and ignores a push
        fifo_en = 1'b0;
        step(1'b1, 8'h33, 1'b0, 1'b0);
        chk("R10 level", int'(level), 0);
        chk("R10 tout", int'(tout_irq), 0);

        // R3 single-byte mode
        step(1'b1, 8'hA1, 1'b0, 1'b0);
        chk("R3 level", int'(level), 1);
        chk("R6 single trig", int'(trig_irq), 1);
        step(1'b1, 8'hB2, 1'b0, 1'b0);
        chk("R3 capacity", int'(level), 1);
        chk("R4 single overrun", int'(overrun), 1);
        chk("R3 head", int'(head_data), 8'hA1);
        for (int k = 0; k < 6; k++) step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R9 no tout single", int'(tout_irq), 0);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R3 empty", int'(empty), 1);
        chk("R7 single trig clear", int'(trig_irq), 0);

        // R11 push and pop together at full
        set_mode(1'b1);
        for (int i = 0; i < 16; i++) step(1'b1, 8'(8'h40 + i), 1'b0, 1'b0);
        step(1'b1, 8'h7F, 1'b1, 1'b0);
        chk("R11 level", int'(level), 16);
        chk("R11 overrun", int'(overrun), 0);
        chk("R11 head", int'(head_data), 8'h41);
        for (int i = 0; i < 15; i++) step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R11 queued byte", int'(head_data), 8'h7F);
        chk("R11 last level", int'(level), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule